// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, in a single combinational pass, whether a conditional branch is taken and which address the front end should fetch next. A decoder supplies a 2-bit branch class, the condition fields of the instruction, the two register operands, the short and long offset fields, the address of the branch and its fall-through address. The block answers with a taken flag and the next program counter.

Four classes of branch are handled. Register-pair branches compare or bit-test two operands. Immediate-constant branches compare one operand against a small constant chosen by a 4-bit index from a signed or an unsigned constant set. Zero branches compare one operand against zero and carry a longer offset. A taken branch goes to the branch address plus four plus the sign-extended offset. A branch that is not taken continues at the fall-through address.

There is no sequential state. The "states" of the block are the four class paths (PAIR, CONST_S, CONST_U, ZERO). Each evaluation selects exactly one of them through `br_class` and then follows one of two transitions: TAKEN, to the computed target, or FALL, to `seq_pc`.

Top module: `branch_resolver`

## Requirements
- R1: With `br_class`=1 (signed constant), the constant picked by `rel_code` indices 0..15 is -1, 1, 2, 3, 4, 5, 6, 7, 8, 10, 12, 16, 32, 64, 128, 256.
- R2: With `br_class`=2 (unsigned constant), the constant set equals the signed one except that index 0 gives 32768 and index 1 gives 65536.
- R3: For `br_class`=1 and `br_class`=3 (compare with zero), `cond_sel` 0 means equal, 1 not-equal, 2 signed less-than and 3 signed greater-or-equal, with `opnd_a` on the left-hand side.
- R4: For `br_class`=0 (register pair), `rel_code[3]` inverts the sense. `rel_code[2:0]` = 1 tests a==b, 2 tests signed a<b and 3 tests unsigned a<b; with bit 3 set these become not-equal, signed greater-or-equal and unsigned greater-or-equal.
- R5: In a register-pair branch, `rel_code[2:0]`=0 is taken when (a AND b) is zero (bit 3 clear) or non-zero (bit 3 set). `rel_code[2:0]`=4 is taken when (a AND b) equals b (bit 3 clear) or differs from b (bit 3 set).
- R6: In a register-pair branch, `rel_code[2:0]`=5 tests bit (b mod 32) of a: taken if that bit is 0 when `rel_code[3]`=0, and if it is 1 when `rel_code[3]`=1.
- R7: In a register-pair branch, `rel_code[2:0]` of 6 or 7 tests bit {`rel_code[0]`, `bit_lo`} of a, with the same clear/set polarity taken from `rel_code[3]`.
- R8: A taken branch sets `next_pc` to `cur_pc` + 4 + sign-extended `off_short` for classes 0, 1 and 2, and to `cur_pc` + 4 + sign-extended `off_long` for class 3, modulo 2^32.
- R9: A branch that is not taken sets `next_pc` equal to `seq_pc`, and `br_taken` is 0.
- R10: In an unsigned-constant branch, `cond_sel`=2 selects unsigned a < constant; every other `cond_sel` value selects unsigned a >= constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| br_class | input | 2 | Branch class: 0 pair, 1 signed constant, 2 unsigned constant, 3 zero |
| cond_sel | input | 2 | Condition code for constant and zero classes |
| rel_code | input | 4 | Pair test code with polarity bit; constant index in constant classes |
| bit_lo | input | 4 | Low four bits of the immediate bit number |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (pair class only) |
| off_short | input | 8 | Signed offset for classes 0, 1 and 2 |
| off_long | input | 12 | Signed offset for class 3 |
| cur_pc | input | 32 | Address of the branch |
| seq_pc | input | 32 | Fall-through address |
| br_taken | output | 1 | Branch is taken |
| next_pc | output | 32 | Address to fetch next |

## Verification
The bound checker tests these properties on every evaluation: the FALL transition always yields `seq_pc`, and the TAKEN transition always yields the offset target that belongs to the class. It also recomputes the equality, zero and mask-test decisions from the operands. The individual entries of both constant sets, the unsigned condition selection, and the exact bit chosen by the register and immediate bit tests are shown only by the bench scenarios, which include the sign boundaries of both offsets and the highest bit positions.

// File: rtl/brr_pkg.sv
`timescale 1ns/1ps
package brr_pkg;

    typedef enum logic [1:0] {
        CLS_PAIR    = 2'd0,
        CLS_CONST_S = 2'd1,
        CLS_CONST_U = 2'd2,
        CLS_ZERO    = 2'd3
    } brr_class_e;

    // Low three bits of the pair test code
    typedef enum logic [2:0] {
        PT_MASK_NONE = 3'd0,
        PT_EQ        = 3'd1,
        PT_LT        = 3'd2,
        PT_LTU       = 3'd3,
        PT_MASK_ALL  = 3'd4,
        PT_BIT_REG   = 3'd5,
        PT_BIT_IMM0  = 3'd6,
        PT_BIT_IMM1  = 3'd7
    } brr_pair_e;

    // Condition codes shared by the signed-constant and zero classes
    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_NE = 2'd1,
        CC_LT = 2'd2,
        CC_GE = 2'd3
    } brr_cc_e;

endpackage

// File: rtl/brr_const_lut.sv
`timescale 1ns/1ps
module brr_const_lut #(
    parameter int XLEN         = 32,
    parameter bit UNSIGNED_SET = 1'b0
) (
    input  logic [3:0]      idx,
    output logic [XLEN-1:0] value
);
    localparam int POW_BIAS = 7;   // index 11 -> 2^4 ... index 15 -> 2^8

    logic [XLEN-1:0] val_idx0;
    logic [XLEN-1:0] val_idx1;
    logic [XLEN-1:0] one_w;

    assign one_w = {{(XLEN-1){1'b0}}, 1'b1};

    generate
        if (UNSIGNED_SET) begin : g_unsigned
            assign val_idx0 = XLEN'(32768);
            assign val_idx1 = XLEN'(65536);
        end else begin : g_signed
            assign val_idx0 = '1;
            assign val_idx1 = one_w;
        end
    endgenerate

    always_comb begin
        unique case (idx)
            4'd0:    value = val_idx0;
            4'd1:    value = val_idx1;
            4'd9:    value = XLEN'(10);
            4'd10:   value = XLEN'(12);
            4'd11, 4'd12, 4'd13, 4'd14, 4'd15:
                     value = one_w << (idx - 4'(POW_BIAS));
            default: value = XLEN'(idx);
        endcase
    end
endmodule

// File: rtl/brr_cond_eval.sv
`timescale 1ns/1ps
module brr_cond_eval
    import brr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  brr_class_e      cls,
    input  logic [1:0]      cond_sel,
    input  logic [3:0]      rel_code,
    input  logic [3:0]      bit_lo,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [XLEN-1:0] k_signed,
    input  logic [XLEN-1:0] k_unsigned,
    output logic            taken
);
    localparam int IDX_W = $clog2(XLEN);

    function automatic logic cmp_signed(input logic [1:0] sel,
                                        input logic [XLEN-1:0] lhs,
                                        input logic [XLEN-1:0] rhs);
        logic res;
        unique case (brr_cc_e'(sel))
            CC_EQ: res = (lhs == rhs);
            CC_NE: res = (lhs != rhs);
            CC_LT: res = ($signed(lhs) < $signed(rhs));
            CC_GE: res = ($signed(lhs) >= $signed(rhs));
        endcase
        return res;
    endfunction

    logic            pair_base;
    logic            pair_sense;
    logic [XLEN-1:0] and_ab;
    logic [IDX_W-1:0] reg_bit;
    logic [IDX_W-1:0] imm_bit;
    brr_pair_e        pair_kind;

    assign pair_kind  = brr_pair_e'(rel_code[2:0]);
    assign pair_sense = rel_code[3];
    assign and_ab     = opnd_a & opnd_b;
    assign reg_bit    = opnd_b[IDX_W-1:0];
    assign imm_bit    = IDX_W'({rel_code[0], bit_lo});

    // Base condition with the sense bit clear; the sense bit flips it
    always_comb begin
        unique case (pair_kind)
            PT_MASK_NONE:             pair_base = (and_ab == '0);
            PT_EQ:                    pair_base = (opnd_a == opnd_b);
            PT_LT:                    pair_base = ($signed(opnd_a) < $signed(opnd_b));
            PT_LTU:                   pair_base = (opnd_a < opnd_b);
            PT_MASK_ALL:              pair_base = (and_ab == opnd_b);
            PT_BIT_REG:               pair_base = ~opnd_a[reg_bit];
            PT_BIT_IMM0, PT_BIT_IMM1: pair_base = ~opnd_a[imm_bit];
        endcase
    end

    always_comb begin
        unique case (cls)
            CLS_PAIR:    taken = pair_base ^ pair_sense;
            CLS_CONST_S: taken = cmp_signed(cond_sel, opnd_a, k_signed);
            CLS_CONST_U: taken = (cond_sel == 2'd2) ? (opnd_a <  k_unsigned)
                                                    : (opnd_a >= k_unsigned);
            CLS_ZERO:    taken = cmp_signed(cond_sel, opnd_a, '0);
        endcase
    end
endmodule

// File: rtl/brr_target_gen.sv
`timescale 1ns/1ps
module brr_target_gen
    import brr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 12
) (
    input  brr_class_e       cls,
    input  logic             taken,
    input  logic [SHORT_W-1:0] off_short,
    input  logic [LONG_W-1:0]  off_long,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  next_pc
);
    localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

    logic [XLEN-1:0] short_ext;
    logic [XLEN-1:0] long_ext;
    logic [XLEN-1:0] off_sel;
    logic [XLEN-1:0] target;

    assign short_ext = {{(XLEN-SHORT_W){off_short[SHORT_W-1]}}, off_short};
    assign long_ext  = {{(XLEN-LONG_W){off_long[LONG_W-1]}}, off_long};

    // One adder: the offset is chosen before the sum
    assign off_sel = (cls == CLS_ZERO) ? long_ext : short_ext;
    assign target  = cur_pc + PC_STEP + off_sel;

    assign next_pc = taken ? target : seq_pc;
endmodule

// File: rtl/branch_resolver.sv
`timescale 1ns/1ps
module branch_resolver
    import brr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 12
) (
    input  logic [1:0]         br_class,
    input  logic [1:0]         cond_sel,
    input  logic [3:0]         rel_code,
    input  logic [3:0]         bit_lo,
    input  logic [XLEN-1:0]    opnd_a,
    input  logic [XLEN-1:0]    opnd_b,
    input  logic [SHORT_W-1:0] off_short,
    input  logic [LONG_W-1:0]  off_long,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    seq_pc,
    output logic               br_taken,
    output logic [XLEN-1:0]    next_pc
);
    brr_class_e      cls;
    logic [XLEN-1:0] k_signed;
    logic [XLEN-1:0] k_unsigned;

    assign cls = brr_class_e'(br_class);

    brr_const_lut #(.XLEN(XLEN), .UNSIGNED_SET(1'b0)) u_lut_s (
        .idx   (rel_code),
        .value (k_signed)
    );

    brr_const_lut #(.XLEN(XLEN), .UNSIGNED_SET(1'b1)) u_lut_u (
        .idx   (rel_code),
        .value (k_unsigned)
    );

    brr_cond_eval #(.XLEN(XLEN)) u_eval (
        .cls        (cls),
        .cond_sel   (cond_sel),
        .rel_code   (rel_code),
        .bit_lo     (bit_lo),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .k_signed   (k_signed),
        .k_unsigned (k_unsigned),
        .taken      (br_taken)
    );

    brr_target_gen #(.XLEN(XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_tgt (
        .cls       (cls),
        .taken     (br_taken),
        .off_short (off_short),
        .off_long  (off_long),
        .cur_pc    (cur_pc),
        .seq_pc    (seq_pc),
        .next_pc   (next_pc)
    );
endmodule

// File: rtl/brr_checker.sv
`timescale 1ns/1ps
module brr_checker #(
    parameter int XLEN    = 32,
    parameter int SHORT_W = 8,
    parameter int LONG_W  = 12
) (
    input logic [1:0]         br_class,
    input logic [1:0]         cond_sel,
    input logic [3:0]         rel_code,
    input logic [3:0]         bit_lo,
    input logic [XLEN-1:0]    opnd_a,
    input logic [XLEN-1:0]    opnd_b,
    input logic [SHORT_W-1:0] off_short,
    input logic [LONG_W-1:0]  off_long,
    input logic [XLEN-1:0]    cur_pc,
    input logic [XLEN-1:0]    seq_pc,
    input logic               br_taken,
    input logic [XLEN-1:0]    next_pc
);
    logic [XLEN-1:0] tgt_short;
    logic [XLEN-1:0] tgt_long;

    always_comb begin
        tgt_short = cur_pc + XLEN'(4) + XLEN'($signed(off_short));
        tgt_long  = cur_pc + XLEN'(4) + XLEN'($signed(off_long));

        AST_FALL_THROUGH: assert (br_taken || next_pc == seq_pc); // R9
        AST_TARGET_SHORT: assert (!br_taken || br_class == 2'd3 || next_pc == tgt_short); // R8
        AST_TARGET_LONG: assert (!br_taken || br_class != 2'd3 || next_pc == tgt_long); // R8
        AST_ZERO_EQ: assert (!(br_class == 2'd3 && cond_sel == 2'd0) || br_taken == (opnd_a == '0)); // R3
        AST_PAIR_EQ: assert (!(br_class == 2'd0 && rel_code[2:0] == 3'd1) || br_taken == ((opnd_a == opnd_b) ^ rel_code[3])); // R4
        AST_MASK_NONE: assert (!(br_class == 2'd0 && rel_code[2:0] == 3'd0) || br_taken == (((opnd_a & opnd_b) == '0) ^ rel_code[3])); // R5
        AST_MASK_ALL: assert (!(br_class == 2'd0 && rel_code[2:0] == 3'd4) || br_taken == (((opnd_a & opnd_b) == opnd_b) ^ rel_code[3])); // R5
    end
endmodule

bind branch_resolver brr_checker #(.XLEN(XLEN), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_chk (.*);

// File: tb/branch_resolver_bench.sv
`timescale 1ns/1ps
module branch_resolver_bench;

    typedef struct {
        logic        exp_taken;
        logic [31:0] exp_pc;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic [1:0]  br_class  = '0;
    logic [1:0]  cond_sel  = '0;
    logic [3:0]  rel_code  = '0;
    logic [3:0]  bit_lo    = '0;
    logic [31:0] opnd_a    = '0;
    logic [31:0] opnd_b    = '0;
    logic [7:0]  off_short = '0;
    logic [11:0] off_long  = '0;
    logic [31:0] cur_pc    = '0;
    logic [31:0] seq_pc    = '0;
    logic        br_taken;
    logic [31:0] next_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    sb_item_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    branch_resolver u_branch_resolver (
        .br_class (br_class), .cond_sel (cond_sel), .rel_code (rel_code),
        .bit_lo (bit_lo), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .off_short (off_short), .off_long (off_long), .cur_pc (cur_pc),
        .seq_pc (seq_pc), .br_taken (br_taken), .next_pc (next_pc)
    );

    // Constant sets as stated in R1 and R2
    function automatic logic [31:0] k_model(bit uns, logic [3:0] i);
        case (i)
            4'd0:  return uns ? 32'd32768 : 32'hFFFF_FFFF;
            4'd1:  return uns ? 32'd65536 : 32'd1;
            4'd9:  return 32'd10;
            4'd10: return 32'd12;
            4'd11: return 32'd16;
            4'd12: return 32'd32;
            4'd13: return 32'd64;
            4'd14: return 32'd128;
            4'd15: return 32'd256;
            default: return {28'd0, i};
        endcase
    endfunction

    function automatic logic taken_model(logic [1:0] cls, logic [1:0] cs, logic [3:0] rc,
                                         logic [3:0] bl, logic [31:0] a, logic [31:0] b);
        logic t;
        int sa, sb;
        sa = int'(a);
        sb = int'(b);
        t = 1'b0;
        if (cls == 2'd0) begin
            case (rc[2:0])
                3'd0: t = ((a & b) == 0);
                3'd1: t = (a == b);
                3'd2: t = (sa < sb);
                3'd3: t = (a < b);
                3'd4: t = ((a & b) == b);
                3'd5: t = (((a >> (b % 32)) & 32'd1) == 0);
                default: t = (((a >> {rc[0], bl}) & 32'd1) == 0);
            endcase
            if (rc[3]) t = !t;
        end else if (cls == 2'd2) begin
            t = (cs == 2'd2) ? (a < k_model(1, rc)) : !(a < k_model(1, rc));
        end else begin
            sb = (cls == 2'd1) ? int'(k_model(0, rc)) : 0;
            case (cs)
                2'd0: t = (sa == sb);
                2'd1: t = (sa != sb);
                2'd2: t = (sa < sb);
                default: t = (sa >= sb);
            endcase
        end
        return t;
    endfunction

    // Driver: applies one branch and pushes the expected outcome
    task automatic drive(input logic [1:0] cls, input logic [1:0] cs, input logic [3:0] rc,
                         input logic [3:0] bl, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] o8, input logic [11:0] o12,
                         input logic [31:0] pc, input logic [31:0] fall, input string tag);
        sb_item_t it;
        int off;
        @(posedge clk);
        br_class = cls; cond_sel = cs; rel_code = rc; bit_lo = bl;
        opnd_a = a; opnd_b = b; off_short = o8; off_long = o12;
        cur_pc = pc; seq_pc = fall;
        it.exp_taken = taken_model(cls, cs, rc, bl, a, b);
        off = (cls == 2'd3) ? int'($signed(o12)) : int'($signed(o8));
        it.exp_pc = it.exp_taken ? (pc + 32'd4 + 32'(off)) : fall;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares away from the driving edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (br_taken !== it.exp_taken || next_pc !== it.exp_pc) begin
                n_fail++;
                $display("FAIL %s: taken=%0b next_pc=%08h expected taken=%0b next_pc=%08h",
                         it.tag, br_taken, next_pc, it.exp_taken, it.exp_pc);
            end
        end
    end

    initial begin
        // idle vector: all zero, pair mask-none test, a&b==0
        drive(0, 0, 4'd0,  0, 32'h0, 32'h0, 8'h00, 12'h000, 32'h0, 32'h3, "R5 idle");
        drive(0, 0, 4'd1,  0, 32'h1234, 32'h1234, 8'hFE, 0, 32'h1000, 32'h1003, "R4 eq");
        drive(0, 0, 4'd9,  0, 32'h1234, 32'h1234, 8'hFE, 0, 32'h1000, 32'h1003, "R4 R9 ne");
        drive(0, 0, 4'd2,  0, 32'hFFFF_FFFB, 32'd3, 8'h7F, 0, 32'h1000, 32'h1003, "R4 lt");
        drive(0, 0, 4'd10, 0, 32'hFFFF_FFFB, 32'd3, 8'h7F, 0, 32'h1000, 32'h1003, "R4 ge");
        drive(0, 0, 4'd3,  0, 32'd1, 32'hFFFF_FFFF, 8'h80, 0, 32'h2000, 32'h2003, "R4 ltu");
        drive(0, 0, 4'd11, 0, 32'd1, 32'hFFFF_FFFF, 8'h80, 0, 32'h2000, 32'h2003, "R4 geu");
        drive(0, 0, 4'd8,  0, 32'd1, 32'd2, 8'h10, 0, 32'h2000, 32'h2003, "R5 any");
        drive(0, 0, 4'd4,  0, 32'h0000_F0F0, 32'h0000_00F0, 8'h10, 0, 32'h2000, 32'h2003, "R5 all");
        drive(0, 0, 4'd12, 0, 32'h0000_F0F0, 32'h0000_0F0F, 8'h10, 0, 32'h2000, 32'h2003, "R5 nall");
        drive(0, 0, 4'd5,  0, 32'h8000_0000, 32'd63, 8'h10, 0, 32'h2000, 32'h2003, "R6 bit clear");
        drive(0, 0, 4'd13, 0, 32'h8000_0000, 32'd63, 8'h10, 0, 32'h2000, 32'h2003, "R6 bit set");
        drive(0, 0, 4'd15, 4'hF, 32'h8000_0000, 32'd0, 8'h04, 0, 32'h3000, 32'h3003, "R7 imm bit31 set");
        drive(0, 0, 4'd6,  4'h3, 32'hFFFF_FFF7, 32'd0, 8'h04, 0, 32'h3000, 32'h3003, "R7 imm bit3 clear");
        drive(0, 0, 4'd7,  4'h0, 32'h0000_0001, 32'd0, 8'h04, 0, 32'h3000, 32'h3003, "R7 imm bit16 clear");
        drive(1, 0, 4'd0,  0, 32'hFFFF_FFFF, 0, 8'h20, 0, 32'h4000, 32'h4003, "R1 idx0 eq");
        drive(1, 2, 4'd15, 0, 32'd255, 0, 8'h20, 0, 32'h4000, 32'h4003, "R1 R3 idx15 lt");
        drive(1, 3, 4'd9,  0, 32'd9, 0, 8'h20, 0, 32'h4000, 32'h4003, "R1 R3 idx9 ge");
        drive(1, 1, 4'd12, 0, 32'd32, 0, 8'h20, 0, 32'h4000, 32'h4003, "R1 R3 idx12 ne");
        drive(2, 2, 4'd0,  0, 32'd32767, 0, 8'h08, 0, 32'h5000, 32'h5003, "R2 R10 idx0 ltu");
        drive(2, 3, 4'd1,  0, 32'd65536, 0, 8'h08, 0, 32'h5000, 32'h5003, "R2 R10 idx1 geu");
        drive(2, 0, 4'd3,  0, 32'd2, 0, 8'h08, 0, 32'h5000, 32'h5003, "R10 sel0 geu");
        drive(2, 2, 4'd1,  0, 32'hFFFF_FFFF, 0, 8'h08, 0, 32'h5000, 32'h5003, "R2 R10 ltu big");
        drive(3, 2, 0, 0, 32'h8000_0000, 0, 8'h00, 12'h800, 32'h0001_0000, 32'h0001_0003, "R3 R8 ltz");
        drive(3, 3, 0, 0, 32'h0, 0, 8'h00, 12'h7FF, 32'h0001_0000, 32'h0001_0003, "R3 R8 gez");
        drive(3, 0, 0, 0, 32'h5, 0, 8'hFF, 12'h7FF, 32'h0001_0000, 32'h0001_0003, "R3 R9 eqz miss");
        drive(3, 1, 0, 0, 32'h5, 0, 8'h00, 12'hFFC, 32'hFFFF_FFFC, 32'h0, "R3 R8 nez wrap");
        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule